// File: doc/BRIEF.md
# I2C Bit Serializer with Timed Data Placement

This block drives one bit onto an open-drain two-wire bus for each transfer it accepts. A bit is offered on a valid/ready input. On acceptance the block pulls the clock line low for a low phase, releases it for a high phase, and then pulls it low again. It keeps the clock line low until the next bit arrives, so a byte engine above it can send bits back to back without a gap.

The data line does not change at the clock's falling edge. The change is a timed event inside the low phase. It comes a minimum hold interval after the low phase begins, which covers the slowest allowed fall of the clock line. It also leaves at least a minimum setup interval before the clock is released. Every interval is a count of system clock cycles, derived from the clock frequency and the bus frequency parameters. Elaboration stops if the hold interval plus the setup interval does not fit in the low phase.

For an acknowledge bit the block releases the data line and reads the bus back at the middle of the high phase. It reports the value read on `ack_rx`. A one-cycle `done` marks the end of every bit.

Back-pressure rules: a bit is taken on a rising clock edge where `bit_valid` and `bit_ready` are both high. `bit_ready` is low while a bit is in flight. The sender must hold its bit until it is accepted. Input values offered while `bit_ready` is low have no effect on the bus.

Top module: `i2c_bit_serializer`

## Requirements
- R1: During reset `scl_oe`, `sda_oe`, `done` and `ack_rx` are 0, and `bit_ready` is 1.
- R2: A bit is accepted on an edge with `bit_valid` and `bit_ready` both high. `bit_ready` is 0 from the next cycle until the cycle in which `done` is 1, when it returns to 1. Values on `bit_valid`, `bit_data` and `bit_is_ack` while `bit_ready` is 0 change no output.
- R3: With PER = CLK_HZ/SCL_HZ, HIGH = PER/2 and LOW = PER-HIGH, `scl_oe` is 1 for the LOW cycles that follow the acceptance edge. It is then 0 for HIGH cycles. After that it returns to 1 and stays 1 while idle.
- R4: `sda_oe` takes the new bit's value exactly HOLD cycles after the acceptance edge, with HOLD = ceil(CLK_HZ·HOLD_NS/1e9) (60 cycles for 300 ns at 200 MHz).
- R5: The last `sda_oe` change before `scl_oe` goes 0 is at least SETUP = ceil(CLK_HZ·SETUP_NS/1e9) cycles earlier. Elaboration fails if HOLD+SETUP exceeds LOW, if HOLD is 0, or if HIGH is below 2.
- R6: Open-drain encoding: for a data bit (`bit_is_ack`=0), `bit_data`=1 gives `sda_oe`=0 (line released) and `bit_data`=0 gives `sda_oe`=1 (line pulled low). The same encoding applies to `scl_oe`.
- R7: For an acknowledge bit (`bit_is_ack`=1), `sda_oe` becomes 0 at the hold point. `sda_i` is sampled on the edge HIGH/2 cycles into the high phase, and `ack_rx` shows the sampled value from the next cycle on.
- R8: `done` is 1 for exactly one cycle. That cycle is the first cycle of `scl_oe`=1 after the high phase.
- R9: `sda_oe` never changes in a cycle where `scl_oe` is 0.
- R10: `ack_rx` keeps its value through data bits, whatever `sda_i` does, until the next acknowledge sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bit_valid | input | 1 | A bit is offered |
| bit_ready | output | 1 | Block is idle and takes the offered bit |
| bit_data | input | 1 | Value of a data bit |
| bit_is_ack | input | 1 | Bit is an acknowledge slot: release the data line and read it back |
| scl_oe | output | 1 | 1 pulls the clock line low, 0 releases it |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_i | input | 1 | Data line as read from the bus |
| done | output | 1 | One-cycle pulse at the end of a bit |
| ack_rx | output | 1 | Last value read back in an acknowledge slot |

## Verification
The hardest situation to reach from the ports is a wrong value on the data line sampled at the wrong point of the high phase. A read-back that is merely early or late still returns the right value if the bus level is constant. The stimulus therefore drives the expected acknowledge level on `sda_i` only while the clock line is released, and the opposite level during the low phase. During data bits it drives random values on `sda_i`. While the block is busy the stimulus also keeps offering random bits, so that an accept that leaks through the back-pressure shows up on the bus at once.

// File: rtl/i2c_bit_pkg.sv
package i2c_bit_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

  // Rounds a nanosecond interval up to whole system clock cycles.
  function automatic int ns_to_cycles(longint clk_hz, longint ns);
    return int'((clk_hz * ns + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/i2c_phase_timer.sv
module i2c_phase_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         restart,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (restart) count <= '0;
    else if (en)      count <= count + 1'b1;
  end
endmodule

// File: rtl/i2c_sda_path.sv
module i2c_sda_path (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic pull_low,
  input  logic sample,
  input  logic sda_i,
  output logic sda_oe,
  output logic ack_rx
);
  // Drive register: changes only on the timed load strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sda_oe <= 1'b0;
    else if (load) sda_oe <= pull_low;
  end

  // Read-back register: captures the bus only in an acknowledge slot.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ack_rx <= 1'b0;
    else if (sample) ack_rx <= sda_i;
  end
endmodule

// File: rtl/i2c_bit_serializer.sv
module i2c_bit_serializer
  import i2c_bit_pkg::*;
#(
  parameter int CLK_HZ   = 100_000_000,
  parameter int SCL_HZ   = 100_000,
  parameter int HOLD_NS  = 300,
  parameter int SETUP_NS = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_valid,
  output logic bit_ready,
  input  logic bit_data,
  input  logic bit_is_ack,
  output logic scl_oe,
  output logic sda_oe,
  input  logic sda_i,
  output logic done,
  output logic ack_rx
);
  localparam int PERIOD_CYC = CLK_HZ / SCL_HZ;
  localparam int HIGH_CYC   = PERIOD_CYC / 2;
  localparam int LOW_CYC    = PERIOD_CYC - HIGH_CYC;
  localparam int HOLD_CYC   = ns_to_cycles(CLK_HZ, HOLD_NS);
  localparam int SETUP_CYC  = ns_to_cycles(CLK_HZ, SETUP_NS);
  localparam int SAMPLE_CYC = HIGH_CYC / 2;
  localparam int CW = $clog2((LOW_CYC > HIGH_CYC ? LOW_CYC : HIGH_CYC) + 1);

  localparam logic [CW-1:0] LOW_LAST  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_LAST = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] HOLD_AT   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] SAMPLE_AT = CW'(SAMPLE_CYC - 1);

  // Elaboration-time timing checks
  if (HOLD_CYC + SETUP_CYC > LOW_CYC) begin : g_low_too_short
    $error("low phase cannot hold both the hold and setup intervals");
  end
  if (HOLD_CYC < 1) begin : g_hold_zero
    $error("hold interval must be at least one cycle");
  end
  if (HIGH_CYC < 2) begin : g_high_too_short
    $error("high phase must be at least two cycles");
  end

  phase_e        phase_q;
  logic          scl_q, done_q, bit_q, ack_q;
  logic [CW-1:0] cnt;
  logic          accept, low_end, high_end;

  assign accept   = (phase_q == PH_IDLE) && bit_valid;
  assign low_end  = (phase_q == PH_LOW)  && (cnt == LOW_LAST);
  assign high_end = (phase_q == PH_HIGH) && (cnt == HIGH_LAST);

  i2c_phase_timer #(.W(CW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (phase_q != PH_IDLE),
    .restart (accept || low_end),
    .count   (cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      scl_q   <= 1'b0;
      done_q  <= 1'b0;
      bit_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (accept) begin
          phase_q <= PH_LOW;
          scl_q   <= 1'b1;
          bit_q   <= bit_data;
          ack_q   <= bit_is_ack;
        end
        PH_LOW: if (low_end) begin
          phase_q <= PH_HIGH;
          scl_q   <= 1'b0;
        end
        PH_HIGH: if (high_end) begin
          phase_q <= PH_IDLE;
          scl_q   <= 1'b1;
          done_q  <= 1'b1;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  i2c_sda_path u_sda (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     ((phase_q == PH_LOW) && (cnt == HOLD_AT)),
    .pull_low (!ack_q && !bit_q),
    .sample   ((phase_q == PH_HIGH) && (cnt == SAMPLE_AT) && ack_q),
    .sda_i    (sda_i),
    .sda_oe   (sda_oe),
    .ack_rx   (ack_rx)
  );

  assign bit_ready = (phase_q == PH_IDLE);
  assign scl_oe    = scl_q;
  assign done      = done_q;
endmodule

// File: rtl/i2c_bit_serializer_chk.sv
module i2c_bit_serializer_chk #(
  parameter int HOLD_CYC  = 1,
  parameter int SETUP_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic done,
  input logic bit_valid,
  input logic bit_ready
);
  localparam int SAT = 1 << 30;

  int   fall_cnt;
  int   sda_age;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fall_cnt <= 0;
      sda_age  <= SAT;
      sda_prev <= 1'b0;
    end else begin
      fall_cnt <= scl_oe ? ((fall_cnt < SAT) ? fall_cnt + 1 : fall_cnt) : 0;
      sda_prev <= sda_oe;
      sda_age  <= (sda_oe != sda_prev) ? 1 : ((sda_age < SAT) ? sda_age + 1 : sda_age);
    end
  end

  // R9
  sda_still_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !scl_oe |-> $stable(sda_oe));

  // R4
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> fall_cnt >= HOLD_CYC);

  // R5
  setup_before_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> sda_age >= SETUP_CYC);

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  done_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (scl_oe && !$past(scl_oe)));

  // R2
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && bit_ready) |=> !bit_ready);

endmodule

bind i2c_bit_serializer i2c_bit_serializer_chk #(
  .HOLD_CYC  (HOLD_CYC),
  .SETUP_CYC (SETUP_CYC)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_oe    (scl_oe),
  .sda_oe    (sda_oe),
  .done      (done),
  .bit_valid (bit_valid),
  .bit_ready (bit_ready)
);

// File: tb/tb_i2c_bit_serializer.sv
`timescale 1ns/1ps
module tb_i2c_bit_serializer;
  localparam int CLK_HZ = 200_000_000;
  localparam int SCL_HZ = 400_000;
  localparam int PER    = CLK_HZ / SCL_HZ;
  localparam int HI     = PER / 2;
  localparam int LO     = PER - HI;
  localparam int HOLD   = 60;   // 300 ns at 200 MHz
  localparam int SETUP  = 50;   // 250 ns at 200 MHz
  localparam int SAMP   = HI / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_valid = 1'b0, bit_data = 1'b0, bit_is_ack = 1'b0, sda_i = 1'b1;
  logic bit_ready, scl_oe, sda_oe, done, ack_rx;

  always #2.5 clk = ~clk;

  i2c_bit_serializer #(.CLK_HZ(CLK_HZ), .SCL_HZ(SCL_HZ)) dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_ready(bit_ready),
    .bit_data(bit_data), .bit_is_ack(bit_is_ack), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_i(sda_i), .done(done), .ack_rx(ack_rx)
  );

  typedef struct { bit data; bit is_ack; bit lvl; int gap; } item_t;
  item_t items[$];

  int tests = 0, fails = 0;
  int cyc = 0, last_sda_change = -1000;
  bit prev_scl = 1'b0, prev_sda = 1'b0;

  bit m_busy = 1'b0, m_data = 1'b0, m_ack = 1'b0, m_lvl = 1'b0;
  int c = 0, gap_cnt = 0;
  bit exp_scl = 1'b0, exp_sda = 1'b0, exp_done = 1'b0, exp_ready = 1'b1, exp_ackrx = 1'b0;

  task automatic chk(string req, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic add(bit d, bit a, bit l, int g);
    item_t it;
    it.data = d; it.is_ack = a; it.lvl = l; it.gap = g;
    items.push_back(it);
  endtask

  task automatic step();
    bit accepting;
    cyc++;
    // compare against the reference model
    chk("R3", "scl_oe", scl_oe, exp_scl);
    chk("R4/R6", "sda_oe", sda_oe, exp_sda);
    chk("R8", "done", done, exp_done);
    chk("R2", "bit_ready", bit_ready, exp_ready);
    chk("R7/R10", "ack_rx", ack_rx, exp_ackrx);
    // R9: data line moves only while clock is pulled low
    if (sda_oe != prev_sda) begin
      chk("R9", "scl_oe at sda change", scl_oe, 1);
      last_sda_change = cyc;
    end
    // R5: setup before clock release
    if (prev_scl && !scl_oe)
      chk("R5", "setup cycles ok", (cyc - last_sda_change) >= SETUP, 1);
    prev_scl = scl_oe;
    prev_sda = sda_oe;

    // drive inputs for the coming edge
    if (exp_ready) begin
      if (items.size() > 0 && gap_cnt >= items[0].gap) begin
        bit_valid  = 1'b1;
        bit_data   = items[0].is_ack ? 1'($urandom % 2) : items[0].data;
        bit_is_ack = items[0].is_ack;
      end else begin
        bit_valid  = 1'b0;
        bit_data   = 1'($urandom % 2);
        bit_is_ack = 1'($urandom % 2);
        gap_cnt++;
      end
    end else begin
      // R2: junk offered while busy must have no effect
      bit_valid  = 1'($urandom % 2);
      bit_data   = 1'($urandom % 2);
      bit_is_ack = 1'($urandom % 2);
    end
    if (m_busy && m_ack)
      sda_i = (c >= LO && c < LO + HI) ? m_lvl : !m_lvl;
    else
      sda_i = 1'($urandom % 2);   // R10: noise outside ack slots

    // advance the model one cycle
    accepting = exp_ready && bit_valid;
    exp_done = 1'b0;
    if (accepting) begin
      m_busy = 1'b1; c = 0;
      m_data = bit_data; m_ack = bit_is_ack; m_lvl = items[0].lvl;
      void'(items.pop_front());
      gap_cnt = 0;
    end else if (m_busy) begin
      c++;
    end
    if (m_busy) begin
      exp_scl = (c < LO) ? 1'b1 : ((c < LO + HI) ? 1'b0 : 1'b1);
      if (c == HOLD) exp_sda = m_ack ? 1'b0 : !m_data;
      if (m_ack && c == LO + SAMP) exp_ackrx = m_lvl;
      if (c == LO + HI) begin
        exp_done = 1'b1; exp_ready = 1'b1; m_busy = 1'b0;
      end else begin
        exp_ready = 1'b0;
      end
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "scl_oe", scl_oe, 0);
    chk("R1", "sda_oe", sda_oe, 0);
    chk("R1", "done", done, 0);
    chk("R1", "bit_ready", bit_ready, 1);
    chk("R1", "ack_rx", ack_rx, 0);
    rst_n = 1'b1;

    add(1, 0, 0, 0);  // released data bit, first from a released clock
    add(0, 0, 0, 0);  // pulled data bit, back to back
    add(0, 0, 0, 3);  // repeated value, after a gap
    add(1, 0, 0, 0);
    add(0, 1, 0, 0);  // R7: slave pulls low
    add(1, 0, 0, 0);  // R10: ack_rx holds through data bits
    add(0, 1, 1, 5);  // R7: no acknowledge seen
    add(0, 0, 0, 0);
    add(0, 1, 0, 0);
    add(0, 1, 1, 0);  // two ack slots back to back
    add(1, 0, 0, 2);

    while (items.size() > 0 || m_busy) begin
      @(negedge clk);
      step();
    end
    repeat (20) begin
      @(negedge clk);
      step();
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule